// File: doc/BRIEF.md
# Serial Configuration Write Port

This block is a write-only slave for a three-wire serial configuration bus (an active-low frame enable, a data line and a bus clock). A host frames each 16-bit word by pulling the enable low, presents bits most significant first, and the slave samples one bit on every rising edge of the bus clock. When the enable returns high, the two bits shifted in last are decoded as an address and one of three 14-bit control registers takes the remaining fourteen bits. The register fields are driven out continuously as parallel control lines to the surrounding radio logic: reference and charge-pump options, output modes, a 12-bit channel word and two test-multiplexer selects.

All three bus wires are synchronized into the system clock and their edges are detected there, so the block runs on a single clock. The host must keep each bus clock phase and the gap around enable transitions at least four system clocks long. There is no readback path and no handshake; the stored values are only observable through the field outputs.

Top module: `cfg3w_slave`

## Requirements
- R1: While `rst_n` is low, and after it is released until a word is committed, every field output is zero.
- R2: While the synchronized enable is low, each rising edge of the bus clock shifts the bus data bit into the shift register, most significant bit of the word first; a 16-bit word has its data field in bits 15:2 and its address in bits 1:0.
- R3: Register contents change only on a low-to-high transition of the enable; a partly or fully shifted word with the enable still low leaves every output unchanged.
- R4: Address 2'b00 writes the configuration register, 2'b01 the channel register and 2'b10 the test register; a write changes only the addressed register.
- R5: A word whose address is 2'b11 is discarded and no output changes.
- R6: Bus clock edges and data while the enable is high are ignored: a later enable fall and rise with no clocks in between commits the word held before them.
- R7: When more than 16 bits are clocked in one frame, only the most recent 16 are committed.
- R8: Configuration word bits map to outputs as: bit 2 `cp_pol`, bit 3 `ref_sel`, bit 4 `aout_mode`, bit 6 `cw_test`, bit 7 `pwr_lvl`, bit 8 `tx_mode`, bit 10 `lvlo_en`, bit 11 `rssi_clip_dis`; bits 5, 9, 13:12 have no effect.
- R9: Channel word bits 13:2 drive `chan_word[11:0]`; bits 15:14 have no effect.
- R10: Test word bits 4:2 drive `atest_sel[2:0]` and bits 7:5 drive `dtest_sel[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en_n | input | 1 | Frame enable, low while a word is shifted, rising edge commits |
| bus_dat | input | 1 | Serial data, MSB first |
| bus_sck | input | 1 | Serial bit clock, sampled on rising edge |
| cp_pol | output | 1 | Charge-pump polarity |
| ref_sel | output | 1 | Reference divide select |
| aout_mode | output | 1 | Analog output pin mode |
| cw_test | output | 1 | Continuous-carrier test enable |
| pwr_lvl | output | 1 | Transmit power level control |
| tx_mode | output | 1 | Transmit output mode |
| lvlo_en | output | 1 | Low-voltage lockout enable |
| rssi_clip_dis | output | 1 | Signal-strength clipping disable |
| chan_word | output | 12 | Channel number |
| atest_sel | output | 3 | Analog test multiplexer select |
| dtest_sel | output | 3 | Digital test multiplexer select |

## Verification
On every cycle the assertions check that registers hold between commit pulses, that an address-3 commit changes nothing, that at most one register is written per commit, and that the shift register moves only on a sampled bus clock edge and takes the synchronized data bit. Field positions, MSB-first order, the discard of clocks while the enable is high and the keep-last-16 rule on over-long frames depend on complete bus transactions, so only the bench's scenarios with known words and expected field values show them.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = WORD_W - ADDR_W;
  localparam int NUM_REGS = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG  = 2'b00,
    A_CHAN = 2'b01,
    A_TEST = 2'b10,
    A_NONE = 2'b11
  } reg_addr_e;

  // word bit positions
  localparam int W_CP   = 2;
  localparam int W_REF  = 3;
  localparam int W_AOUT = 4;
  localparam int W_CW   = 6;
  localparam int W_PWR  = 7;
  localparam int W_TX   = 8;
  localparam int W_LVLO = 10;
  localparam int W_RSSI = 11;
  localparam int CHAN_W  = 12;
  localparam int CHAN_LO = 2;
  localparam int TSEL_W  = 3;
  localparam int AT_LO   = 2;
  localparam int DT_LO   = 5;

  // data-field positions (word position minus address width)
  function automatic int dpos(input int wpos);
    return wpos - ADDR_W;
  endfunction
endpackage

// File: rtl/cfg3w_sync_edge.sv
module cfg3w_sync_edge #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  input  logic [N-1:0] rst_val,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= rst_val;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= rst_val;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= rst_val;
    else        prev <= chain[STAGES-1];

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;

  genvar b;
  generate
    for (b = 0; b < N; b++) begin : g_chk
      // an edge pulse lasts one cycle (R2, R3)
      p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise[b] |=> !rise[b]);
    end
  endgenerate
endmodule

// File: rtl/cfg3w_shifter.sv
module cfg3w_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};

  p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word));
  p_shift_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[0] == $past(din)) && (word[W-1:1] == $past(word[W-2:0])));
endmodule

// File: rtl/cfg3w_regbank.sv
module cfg3w_regbank
  import cfg3w_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             commit,
  input  logic [WORD_W-1:0]                word,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
  logic [ADDR_W-1:0]   addr;
  logic [DATA_W-1:0]   data;
  logic [NUM_REGS-1:0] we;

  assign addr = word[ADDR_W-1:0];
  assign data = word[WORD_W-1:ADDR_W];

  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_reg
      assign we[i] = commit && (addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)     regs[i] <= '0;
        else if (we[i]) regs[i] <= data;

      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs[i]));
      p_bad_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && addr == A_NONE) |=> $stable(regs[i]));
    end
  endgenerate

  p_one_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));
endmodule

// File: rtl/cfg3w_slave.sv
module cfg3w_slave
  import cfg3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en_n,
  input  logic              bus_dat,
  input  logic              bus_sck,
  output logic              cp_pol,
  output logic              ref_sel,
  output logic              aout_mode,
  output logic              cw_test,
  output logic              pwr_lvl,
  output logic              tx_mode,
  output logic              lvlo_en,
  output logic              rssi_clip_dis,
  output logic [CHAN_W-1:0] chan_word,
  output logic [TSEL_W-1:0] atest_sel,
  output logic [TSEL_W-1:0] dtest_sel
);
  localparam int IX_EN  = 2;
  localparam int IX_SCK = 1;
  localparam int IX_DAT = 0;

  logic [2:0] s_lvl, s_rise;
  logic       bit_strobe, commit;
  logic [WORD_W-1:0] sh_word;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0] cfg_d, chan_d, test_d;

  cfg3w_sync_edge #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({bus_en_n, bus_sck, bus_dat}),
    .rst_val  (3'b100),
    .lvl      (s_lvl),
    .rise     (s_rise)
  );

  assign bit_strobe = s_rise[IX_SCK] && !s_lvl[IX_EN];
  assign commit     = s_rise[IX_EN];

  cfg3w_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (bit_strobe),
    .din      (s_lvl[IX_DAT]),
    .word     (sh_word)
  );

  cfg3w_regbank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .word   (sh_word),
    .regs   (regs)
  );

  assign cfg_d  = regs[A_CFG];
  assign chan_d = regs[A_CHAN];
  assign test_d = regs[A_TEST];

  assign cp_pol        = cfg_d[dpos(W_CP)];
  assign ref_sel       = cfg_d[dpos(W_REF)];
  assign aout_mode     = cfg_d[dpos(W_AOUT)];
  assign cw_test       = cfg_d[dpos(W_CW)];
  assign pwr_lvl       = cfg_d[dpos(W_PWR)];
  assign tx_mode       = cfg_d[dpos(W_TX)];
  assign lvlo_en       = cfg_d[dpos(W_LVLO)];
  assign rssi_clip_dis = cfg_d[dpos(W_RSSI)];
  assign chan_word     = chan_d[dpos(CHAN_LO) +: CHAN_W];
  assign atest_sel     = test_d[dpos(AT_LO) +: TSEL_W];
  assign dtest_sel     = test_d[dpos(DT_LO) +: TSEL_W];

  logic unused_fields;
  assign unused_fields = ^{cfg_d[13:10], cfg_d[7], cfg_d[3], chan_d[13:12],
                           test_d[13:6], s_rise[IX_DAT]};
endmodule

// File: tb/cfg3w_slave_tb_top.sv
module cfg3w_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en_n = 1'b1, bus_dat = 1'b0, bus_sck = 1'b0;
  logic cp_pol, ref_sel, aout_mode, cw_test, pwr_lvl, tx_mode, lvlo_en, rssi_clip_dis;
  logic [11:0] chan_word;
  logic [2:0]  atest_sel, dtest_sel;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg3w_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .bus_dat(bus_dat), .bus_sck(bus_sck),
    .cp_pol(cp_pol), .ref_sel(ref_sel), .aout_mode(aout_mode), .cw_test(cw_test),
    .pwr_lvl(pwr_lvl), .tx_mode(tx_mode), .lvlo_en(lvlo_en), .rssi_clip_dis(rssi_clip_dis),
    .chan_word(chan_word), .atest_sel(atest_sel), .dtest_sel(dtest_sel)
  );

  // observed = {cfg8 (cp,ref,aout,cw,pwr,tx,lvlo,rssi), chan12, at3, dt3}
  function automatic logic [25:0] obs();
    return {cp_pol, ref_sel, aout_mode, cw_test, pwr_lvl, tx_mode, lvlo_en,
            rssi_clip_dis, chan_word, atest_sel, dtest_sel};
  endfunction

  // each entry: {word16, expected cfg8, chan12, at3, dt3} after commit (cumulative)
  localparam logic [41:0] VEC [8] = '{
    {16'h0494, 8'hAA, 12'h000, 3'd0, 3'd0},  // R8 cfg bits 2,4,7,10
    {16'hEAF1, 8'hAA, 12'hABC, 3'd0, 3'd0},  // R9 chan, reserved set
    {16'h0076, 8'hAA, 12'hABC, 3'd5, 3'd3},  // R10 test selects
    {16'hFFFF, 8'hAA, 12'hABC, 3'd5, 3'd3},  // R5 address 11
    {16'hFFFC, 8'hFF, 12'hABC, 3'd5, 3'd3},  // R8 all cfg bits
    {16'h0005, 8'hFF, 12'h001, 3'd5, 3'd3},  // R4 chan only
    {16'h0948, 8'h55, 12'h001, 3'd5, 3'd3},  // R8 bits 3,6,8,11
    {16'h0002, 8'h55, 12'h001, 3'd0, 3'd0}   // R4 test only
  };

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check(input string req, input logic [25:0] exp);
    @(negedge clk);
    n_chk++;
    if (obs() !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, obs(), exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      bus_dat = v[k];
      wait_clk(4);
      bus_sck = 1'b1;
      wait_clk(4);
      bus_sck = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    bus_en_n = 1'b0;
    wait_clk(4);
    shift_bits(v, n);
    bus_en_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    wait_clk(3);
    check("R1", 26'h0);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1", 26'h0);

    for (int i = 0; i < 8; i++) begin
      frame({16'h0, VEC[i][41:26]}, 16);
      check($sformatf("R2/R4 vec%0d", i), VEC[i][25:0]);
    end

    // R3: half a word with enable low leaves outputs alone
    bus_en_n = 1'b0;
    wait_clk(4);
    shift_bits(32'h00F1, 8);
    check("R3 mid-frame", {8'h55, 12'h001, 3'd0, 3'd0});
    shift_bits(32'h00C1, 8);         // full word 0xF1C1, chan 0xC70
    wait_clk(10);
    check("R3 full word no rise", {8'h55, 12'h001, 3'd0, 3'd0});
    bus_en_n = 1'b1;
    wait_clk(8);
    check("R3 commit on rise", {8'h55, 12'hC70, 3'd0, 3'd0});

    // R6: clocks while enable high must not shift; recommit same word
    bus_dat = 1'b0;
    for (int k = 0; k < 2; k++) begin
      wait_clk(4); bus_sck = 1'b1; wait_clk(4); bus_sck = 1'b0;
    end
    wait_clk(4);
    bus_en_n = 1'b0;
    wait_clk(8);
    bus_en_n = 1'b1;
    wait_clk(8);
    check("R6 ignore clocks", {8'h55, 12'hC70, 3'd0, 3'd0});

    // R7: 20 bits, last 16 = 0x0025 -> chan 0x009
    frame(32'hF0025, 20);
    check("R7 keep last 16", {8'h55, 12'h009, 3'd0, 3'd0});

    // R8 unused cfg bits 5,9,12,13 alone -> all cfg outputs zero
    frame(32'h3220, 16);
    check("R8 unused bits", {8'h00, 12'h009, 3'd0, 3'd0});

    // R1: reset mid-run
    rst_n = 1'b0;
    wait_clk(2);
    check("R1 reset again", 26'h0);
    rst_n = 1'b1;
    wait_clk(4);
    check("R1 after release", 26'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule